// File: doc/BRIEF.md
# Up/Down Link-Tagging Flag Engine

This block is the per-router control for a distributed, topology-agnostic reconfiguration of a four-port mesh router. Each port has a one-bit incoming flag wire and a one-bit outgoing flag wire. A reconfiguration is a sequence of N broadcast slots of N cycles each, where N is the node count. Slot 0 belongs to the node that detected the fault, which is the root. Every later slot k belongs to the node whose ID is k. A node that is the root does not send again in its own numbered slot.

The first flag a router sees puts it into recovery. That flag sets the router's per-port up/down directions from flag timing alone: a port the flag arrives on is marked up, and a port the flag leaves on is marked down. When a flag is sent and received on the same link in the same cycle, the tie is settled by node ID. In every slot the engine records where the broadcast first arrived and passes that to the routing-table builder as an event. It then forwards the flag one cycle later on the ports that the up/down turn rule allows. While recovery is active the head-flit pipeline is held frozen. When recovery ends, a one-cycle pulse tells the pipeline to restart its head flits at route compute.

Top module: `ud_flag_engine`

## Requirements
- R1: In the normal state, a flag arriving on any live port makes `recovering` and `freeze` high from the next cycle on. That same cycle shows a one-cycle `tbl_inval` pulse and a table event for slot 0 whose port mask equals the arrival mask.
- R2: Recovery lasts exactly NODES*NODES cycles. In the first cycle after it ends, `recovering` and `freeze` are low and `route_restart` pulses for one cycle.
- R3: On entry by an arriving flag, `port_up` becomes the arrival mask. A bit value of 1 means up. Port bit 0 is north, bit 1 east, bit 2 south and bit 3 west.
- R4: During slot 0, a port that receives a flag in a cycle when the node is sending on it becomes up if it is north or west (the neighbour there has a lower ID). If it is east or south, it stays down.
- R5: After slot 0, `port_up` does not change until recovery ends.
- R6: Forwarding happens in the cycle after the first arrival of a slot and never goes out on an arrival port. A flag that arrived only on down ports goes out on every other live port.
- R7: A flag that arrived on at least one up port goes out only on live down ports that it did not arrive on.
- R8: Within one slot, only the first arrival is used. Later flags in that slot produce no event and no forwarding.
- R9: A `fault_start` pulse while in the normal state makes the node the root. From the next cycle, `recovering` is high and the flag goes out on all live ports in that same cycle. All ports are marked down and no table event is produced.
- R10: A non-root node sends the flag on all live ports in the first cycle of slot NODE_ID, with no table event. A root node stays silent in that slot.
- R11: Flags on ports whose `link_ok` bit is low are ignored: no entry, no event, no forwarding.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_start | input | 1 | Local fault detected; start as root |
| link_ok | input | 4 | Live-port mask (N,E,S,W = bits 0..3) |
| flag_in | input | 4 | Incoming flag per port |
| flag_out | output | 4 | Outgoing flag per port |
| recovering | output | 1 | Recovery state |
| freeze | output | 1 | Hold head flits in the pipeline |
| tbl_inval | output | 1 | One-cycle pulse: invalidate routing table |
| tbl_evt_vld | output | 1 | Table event valid |
| tbl_evt_ports | output | 4 | Ports on which the slot's broadcast first arrived |
| tbl_evt_slot | output | clog2(NODES) | Slot number of the event |
| route_restart | output | 1 | One-cycle pulse: restart head flits at route compute |
| port_up | output | 4 | Per-port direction, 1 = up |

## Verification
A wrong direction bit does not stay hidden. It shows at `port_up` immediately, and in the next up-arrival slot it shows as a wrong `flag_out` mask one cycle after the arrival. A slot or phase counter that is off by even one cycle moves the node's own broadcast away from the first cycle of its slot, changes `tbl_evt_slot`, and shifts the fall of `recovering`. The bench compares all of these at the exact cycle the requirements fix. A stuck per-slot seen bit shows either as a second event within one slot or as a missing event in the next slot.

// File: rtl/ud_flag_pkg.sv
package ud_flag_pkg;
  localparam int PORTS = 4;
  typedef enum logic [1:0] {
    P_NORTH = 2'd0,
    P_EAST  = 2'd1,
    P_SOUTH = 2'd2,
    P_WEST  = 2'd3
  } port_e;
  // Ports whose mesh neighbour has a lower ID: this node wins a tie there.
  localparam logic [PORTS-1:0] TIE_WIN = (1 << P_NORTH) | (1 << P_WEST);
endpackage

// File: rtl/ud_slot_timer.sv
module ud_slot_timer #(
  parameter int NODES = 4,
  localparam int CW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rec,
  output logic [CW-1:0] slot,
  output logic          slot_end,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(NODES - 1);

  logic          rec_q, rec_d, done_q, done_d;
  logic [CW-1:0] phase_q, phase_d, slot_q, slot_d;

  always_comb begin
    rec_d   = rec_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    done_d  = 1'b0;
    if (!rec_q && start) begin
      rec_d   = 1'b1;
      phase_d = '0;
      slot_d  = '0;
    end else if (rec_q) begin
      if (phase_q == LAST) begin
        phase_d = '0;
        if (slot_q == LAST) begin
          rec_d  = 1'b0;
          slot_d = '0;
          done_d = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q   <= 1'b0;
      phase_q <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      rec_q   <= rec_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      done_q  <= done_d;
    end
  end

  assign rec      = rec_q;
  assign slot     = slot_q;
  assign slot_end = rec_q && (phase_q == LAST);
  assign done     = done_q;

  a_r2_exit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec && $past(rec));
endmodule

// File: rtl/ud_dir_tagger.sv
module ud_dir_tagger
  import ud_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_root,
  input  logic             start_flag,
  input  logic             slot0,
  input  logic [PORTS-1:0] arr,
  input  logic [PORTS-1:0] sending,
  output logic [PORTS-1:0] up
);
  logic [PORTS-1:0] up_q, up_d, tie;

  assign tie = sending & arr;

  always_comb begin
    up_d = up_q;
    if (start_root) begin
      up_d = '0;
    end else if (start_flag) begin
      up_d = arr;
    end else if (slot0) begin
      for (int p = 0; p < PORTS; p++)
        if (tie[p]) up_d[p] = TIE_WIN[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else        up_q <= up_d;
  end

  assign up = up_q;
endmodule

// File: rtl/ud_fwd_engine.sv
module ud_fwd_engine
  import ud_flag_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_root,
  input  logic             start_flag,
  input  logic             rec,
  input  logic [CW-1:0]    slot,
  input  logic             slot_end,
  input  logic             own_next,
  input  logic [PORTS-1:0] arr,
  input  logic [PORTS-1:0] up,
  input  logic [PORTS-1:0] link_ok,
  output logic [PORTS-1:0] flag_out,
  output logic             evt_vld,
  output logic [PORTS-1:0] evt_ports,
  output logic [CW-1:0]    evt_slot
);
  logic             seen_q, seen_d, take;
  logic [PORTS-1:0] upv, cand, flag_q, flag_d, ports_q, ports_d;
  logic             vld_q;
  logic [CW-1:0]    eslot_q, eslot_d;

  assign take = start_flag || (rec && !seen_q && (|arr));
  assign upv  = start_flag ? arr : up;
  assign cand = link_ok & ~arr & ((|(arr & upv)) ? ~upv : {PORTS{1'b1}});

  always_comb begin
    seen_d = seen_q;
    if (start_root)    seen_d = 1'b1;
    else if (slot_end) seen_d = own_next;
    else if (take)     seen_d = 1'b1;
    flag_d = (take ? cand : '0) | ((own_next || start_root) ? link_ok : '0);
    ports_d = take ? arr : '0;
    eslot_d = start_flag ? '0 : slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      flag_q  <= '0;
      vld_q   <= 1'b0;
      ports_q <= '0;
      eslot_q <= '0;
    end else begin
      seen_q  <= seen_d;
      flag_q  <= flag_d;
      vld_q   <= take;
      ports_q <= ports_d;
      eslot_q <= eslot_d;
    end
  end

  assign flag_out  = flag_q;
  assign evt_vld   = vld_q;
  assign evt_ports = ports_q;
  assign evt_slot  = eslot_q;

  a_r6_no_echo: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> (flag_out & evt_ports) == '0);
  a_r11_live_only: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> (evt_ports & ~$past(link_ok)) == '0);
endmodule

// File: rtl/ud_flag_engine.sv
module ud_flag_engine
  import ud_flag_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int NODE_ID = 2,
  localparam int CW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_start,
  input  logic [3:0]    link_ok,
  input  logic [3:0]    flag_in,
  output logic [3:0]    flag_out,
  output logic          recovering,
  output logic          freeze,
  output logic          tbl_inval,
  output logic          tbl_evt_vld,
  output logic [3:0]    tbl_evt_ports,
  output logic [CW-1:0] tbl_evt_slot,
  output logic          route_restart,
  output logic [3:0]    port_up
);
  logic [PORTS-1:0] arr;
  logic             rec, slot_end, done, start_root, start_flag, own_next;
  logic [CW-1:0]    slot;
  logic             root_q, root_d, inval_q;

  assign arr        = flag_in & link_ok;
  assign start_root = !rec && fault_start;
  assign start_flag = !rec && !fault_start && (|arr);

  generate
    if (NODE_ID > 0 && NODE_ID < NODES) begin : g_own
      assign own_next = slot_end && !root_q && (slot == CW'(NODE_ID - 1));
    end else begin : g_no_own
      assign own_next = 1'b0;
    end
  endgenerate

  always_comb begin
    root_d = root_q;
    if (start_root)      root_d = 1'b1;
    else if (start_flag) root_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q  <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      root_q  <= root_d;
      inval_q <= start_root || start_flag;
    end
  end

  ud_slot_timer #(.NODES(NODES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_root || start_flag),
    .rec(rec), .slot(slot), .slot_end(slot_end), .done(done)
  );

  ud_dir_tagger u_tag (
    .clk(clk), .rst_n(rst_n), .start_root(start_root), .start_flag(start_flag),
    .slot0(rec && (slot == '0)), .arr(arr), .sending(flag_out), .up(port_up)
  );

  ud_fwd_engine #(.CW(CW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .start_root(start_root), .start_flag(start_flag),
    .rec(rec), .slot(slot), .slot_end(slot_end), .own_next(own_next),
    .arr(arr), .up(port_up), .link_ok(link_ok), .flag_out(flag_out),
    .evt_vld(tbl_evt_vld), .evt_ports(tbl_evt_ports), .evt_slot(tbl_evt_slot)
  );

  assign recovering    = rec;
  assign freeze        = rec;
  assign tbl_inval     = inval_q;
  assign route_restart = done;

  a_r1_inval_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_inval |-> recovering && !$past(recovering));
  a_r2_restart_after: assert property (@(posedge clk) disable iff (!rst_n)
    route_restart |-> !freeze && $past(freeze));
  a_r5_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && $past(recovering) && $past(slot) != '0) |-> $stable(port_up));
  a_r9_root_silent_table: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && !$past(recovering) && root_q) |-> !tbl_evt_vld);
endmodule

// File: tb/tb_ud_flag_engine.sv
`timescale 1ns/1ps
module tb_ud_flag_engine;
  localparam int NODES = 4;
  localparam int NODE_ID = 2;

  typedef struct packed {
    logic [3:0] f;
    logic       v;
    logic [3:0] p;
    logic [1:0] s;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic fault_start;
  logic [3:0] link_ok, flag_in, flag_out, tbl_evt_ports, port_up;
  logic recovering, freeze, tbl_inval, tbl_evt_vld, route_restart;
  logic [1:0] tbl_evt_slot;

  int checks = 0;
  int fails = 0;
  bit ended = 0;
  item_t expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  ud_flag_engine #(.NODES(NODES), .NODE_ID(NODE_ID)) dut (
    .clk(clk), .rst_n(rst_n), .fault_start(fault_start), .link_ok(link_ok),
    .flag_in(flag_in), .flag_out(flag_out), .recovering(recovering),
    .freeze(freeze), .tbl_inval(tbl_inval), .tbl_evt_vld(tbl_evt_vld),
    .tbl_evt_ports(tbl_evt_ports), .tbl_evt_slot(tbl_evt_slot),
    .route_restart(route_restart), .port_up(port_up)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic [3:0] f, input logic v,
                            input logic [3:0] p, input logic [1:0] s);
    item_t it;
    it.f = f; it.v = v; it.p = p; it.s = s;
    expq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: every produced output is popped and compared.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (flag_out != 4'b0 || tbl_evt_vld)) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL unexpected output flag=%b vld=%b ports=%b (R8/R11) actual=output expected=none",
                 flag_out, tbl_evt_vld, tbl_evt_ports);
      end else begin
        item_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (flag_out !== e.f || tbl_evt_vld !== e.v ||
            (e.v && (tbl_evt_ports !== e.p || tbl_evt_slot !== e.s))) begin
          fails++;
          $display("FAIL %s actual f=%b v=%b p=%b s=%0d expected f=%b v=%b p=%b s=%0d",
                   t, flag_out, tbl_evt_vld, tbl_evt_ports, tbl_evt_slot,
                   e.f, e.v, e.p, e.s);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fault_start = 1'b0; link_ok = 4'b1111; flag_in = 4'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rec/freeze", {6'b0, recovering, freeze}, 8'h00);
    chk("R12 reset flag_out", {4'b0, flag_out}, 8'h00);
    chk("R12 reset port_up", {4'b0, port_up}, 8'h00);

    // Scenario: entry by arrival on north.
    flag_in = 4'b0001;
    expect_out("R1/R6 entry event slot0 and forward", 4'b1110, 1'b1, 4'b0001, 2'd0);
    tick(); // k=0
    chk("R1 recovering+freeze", {6'b0, recovering, freeze}, 8'h03);
    chk("R1 inval pulse", {7'b0, tbl_inval}, 8'h01);
    chk("R3 arrival marked up", {4'b0, port_up}, 8'h01);
    flag_in = 4'b1000; // tie on west while sending there
    tick(); // k=1
    chk("R4 tie west up, others kept", {4'b0, port_up}, 8'h09);
    chk("R1 inval single cycle", {7'b0, tbl_inval}, 8'h00);
    flag_in = 4'b0010; // repeat in slot 0 -> ignored (R8)
    tick(); // k=2
    flag_in = 4'b0;
    tick(); tick(); // k=4, slot 1
    flag_in = 4'b0010; // east, a down port
    expect_out("R6 down arrival fans out", 4'b1101, 1'b1, 4'b0010, 2'd1);
    tick(); // k=5
    flag_in = 4'b0010; // second arrival same slot
    tick(); // k=6 -> nothing (R8)
    flag_in = 4'b0;
    chk("R8 repeat gives no event", {7'b0, tbl_evt_vld}, 8'h00);
    tick(); // k=7
    expect_out("R10 own broadcast slot NODE_ID", 4'b1111, 1'b0, 4'b0, 2'd0);
    tick(); // k=8
    tick(); tick(); tick(); // k=11
    chk("R5 directions kept", {4'b0, port_up}, 8'h09);
    tick(); // k=12 slot 3
    flag_in = 4'b0011; // north up + east down
    expect_out("R7 up arrival to down ports only", 4'b0100, 1'b1, 4'b0011, 2'd3);
    tick(); // k=13
    flag_in = 4'b0;
    tick(); tick(); // k=15
    chk("R2 still recovering at last cycle", {7'b0, recovering}, 8'h01);
    chk("R5 directions kept late", {4'b0, port_up}, 8'h09);
    tick(); // k=16
    chk("R2 exit after N*N", {6'b0, recovering, freeze}, 8'h00);
    chk("R2 restart pulse", {7'b0, route_restart}, 8'h01);

    // Scenario: root with west dead.
    link_ok = 4'b0111;
    fault_start = 1'b1;
    expect_out("R9 root sends on live ports", 4'b0111, 1'b0, 4'b0, 2'd0);
    tick(); // k'=0
    fault_start = 1'b0;
    chk("R9 root recovering", {7'b0, recovering}, 8'h01);
    chk("R9 root all down", {4'b0, port_up}, 8'h00);
    chk("R2 restart single cycle", {7'b0, route_restart}, 8'h00);
    tick(); tick(); tick(); tick(); // k'=4 slot 1
    flag_in = 4'b1000; // dead west
    tick(); // k'=5
    chk("R11 dead port no event", {7'b0, tbl_evt_vld}, 8'h00);
    flag_in = 4'b0010;
    expect_out("R11/R6 live arrival after dead", 4'b0101, 1'b1, 4'b0010, 2'd1);
    tick(); // k'=6
    flag_in = 4'b0;
    tick(); tick(); // k'=8: root is silent in own slot
    chk("R10 root silent in own slot", {4'b0, flag_out}, 8'h00);
    repeat (8) tick(); // k'=16
    chk("R2 root exit", {7'b0, recovering}, 8'h00);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R6 pending outputs actual=%0d expected=0", expq.size());
    end
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule